// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block produces the raster timing for a parallel RGB display panel: horizontal sync, vertical sync, a data-enable strobe, a one-pixel frame-start marker and the current pixel column and row. It advances on a pixel-clock enable, so one system clock can serve a range of pixel rates. Three 32-bit timing words set it up. The horizontal word gives the active width in units of 16 pixels, plus the sync width and the two porches. The vertical word gives the active line count, the sync width and two porches that carry no bias. The polarity word carries per-output inversion flags, a flag that selects the falling pixel-clock edge for data, and a clocks-per-line field.

Software sets the timing words while the controller is stopped, then raises the enable, then requests panel power. The block enforces the power ordering on its own. Power comes on only after the controller runs. When the enable drops, power goes off first and the controller stops one cycle later. While running, new timing words take effect only at a frame boundary, so a frame is never torn.

Top module: `panel_timing_gen`

## Requirements
- R1: Horizontal word: bits [7:2] = active width/16 − 1, [15:8] = sync width − 1, [23:16] = front porch − 1, [31:24] = back porch − 1. Each line runs active, front porch, sync, back porch, and its length in pixels is the sum of the four.
- R2: Vertical word: bits [9:0] = active lines − 1, [15:10] = sync width − 1, [23:16] = front porch and [31:24] = back porch, both unbiased and allowed to be zero. Each frame runs active, front porch, sync, back porch, counted in lines.
- R3: Data-enable is active only where both the column and the row lie in their active regions.
- R4: frame_start is high for exactly one pixel period, at column 0 of row 0. pix_x and pix_y report the column and row position within the full line and frame, blanking included.
- R5: Polarity word bit 12 inverts hsync, bit 11 inverts vsync and bit 14 inverts data-enable. Each flag affects only its own output, and a clear flag means active-high.
- R6: While the controller is stopped, pix_x and pix_y are 0, frame_start is 0, and hsync, vsync and data-enable sit at their inactive levels.
- R7: panel_pwr rises only after the controller has run for at least one cycle with power requested. When ctl_en falls, panel_pwr drops on the next edge and the controller keeps running for one more cycle.
- R8: While stopped, the block follows the timing words. While running, a change to a timing word takes effect only at the start of the next frame.
- R9: The counters advance only on clocks where pix_ce is high, so every timing interval scales with the pixel-enable rate.
- R10: Polarity bit 13 appears on data_fall_edge. In the default variant, the clocks-per-line field at polarity bits [25:16] has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable |
| ctl_en | input | 1 | Controller enable request |
| pwr_req | input | 1 | Panel power request |
| h_timing | input | 32 | Horizontal timing word |
| v_timing | input | 32 | Vertical timing word |
| pol_ctl | input | 32 | Polarity, edge and clocks-per-line word |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| frame_start | output | 1 | First-pixel-of-frame marker |
| pix_x | output | CNT_W | Column counter |
| pix_y | output | CNT_W | Row counter |
| panel_pwr | output | 1 | Panel power |
| data_fall_edge | output | 1 | Drive pixel data on falling edge |

## Verification
A wrong boundary or counter value shows up within one line as a data-enable run, a sync width or a sync offset that no longer matches the word fields. A wrong row count or porch shows up within one frame in the frame length and the vsync offset, so the bench measures every interval over a whole frame. A shadow register loaded at the wrong time shows up in the frame where a word changes mid-frame: that frame's data-enable total moves early. A faulty power sequence shows up in the cycle right after an enable edge.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
   // horizontal word field positions
   localparam int unsigned HACT_LO = 2;
   localparam int unsigned HACT_W  = 6;
   localparam int unsigned HSW_LO  = 8;
   localparam int unsigned HSW_W   = 8;
   localparam int unsigned HFP_LO  = 16;
   localparam int unsigned HFP_W   = 8;
   localparam int unsigned HBP_LO  = 24;
   localparam int unsigned HBP_W   = 8;
   // vertical word field positions
   localparam int unsigned VACT_LO = 0;
   localparam int unsigned VACT_W  = 10;
   localparam int unsigned VSW_LO  = 10;
   localparam int unsigned VSW_W   = 6;
   localparam int unsigned VFP_LO  = 16;
   localparam int unsigned VFP_W   = 8;
   localparam int unsigned VBP_LO  = 24;
   localparam int unsigned VBP_W   = 8;
   // polarity word bits
   localparam int unsigned PB_INV_V  = 11;
   localparam int unsigned PB_INV_H  = 12;
   localparam int unsigned PB_FALL   = 13;
   localparam int unsigned PB_INV_DE = 14;
   localparam int unsigned CPL_LO    = 16;
   localparam int unsigned CPL_W     = 10;
   // boundary arithmetic width and the smallest counter that spans a maximal line or frame
   localparam int unsigned BND_W     = 16;
   localparam int unsigned MIN_CNT_W = 11;

   typedef logic [BND_W-1:0] bnd_t;

   typedef struct packed {
      bnd_t act_end;     // first position after the active region
      bnd_t sync_start;  // first position of the sync region
      bnd_t sync_end;    // first position after the sync region
      bnd_t last;        // final position before wrap
   } axis_bnd_t;
endpackage

// File: rtl/ptg_decode.sv
module ptg_decode
   import ptg_pkg::*;
#(
   parameter bit ACT_FROM_CPL = 1'b0
) (
   input  logic [31:0] hw,
   input  logic [31:0] vw,
   input  logic [31:0] pw,
   output axis_bnd_t   hb,
   output axis_bnd_t   vb,
   output logic        inv_h,
   output logic        inv_v,
   output logic        inv_de,
   output logic        fall
);
   bnd_t h_act;
   logic unused_fields;

   // variant select: active width from the 16-pixel field or from clocks-per-line
   generate
      if (ACT_FROM_CPL) begin : g_act_cpl
         assign h_act = BND_W'(pw[CPL_LO +: CPL_W]) + bnd_t'(1);
      end else begin : g_act_ppl
         assign h_act = (BND_W'(hw[HACT_LO +: HACT_W]) + bnd_t'(1)) << 4;
      end
   endgenerate

   always_comb begin
      hb.act_end    = h_act;
      hb.sync_start = h_act + BND_W'(hw[HFP_LO +: HFP_W]) + bnd_t'(1);
      hb.sync_end   = hb.sync_start + BND_W'(hw[HSW_LO +: HSW_W]) + bnd_t'(1);
      hb.last       = hb.sync_end + BND_W'(hw[HBP_LO +: HBP_W]);
   end

   always_comb begin
      vb.act_end    = BND_W'(vw[VACT_LO +: VACT_W]) + bnd_t'(1);
      vb.sync_start = vb.act_end + BND_W'(vw[VFP_LO +: VFP_W]);
      vb.sync_end   = vb.sync_start + BND_W'(vw[VSW_LO +: VSW_W]) + bnd_t'(1);
      vb.last       = vb.sync_end + BND_W'(vw[VBP_LO +: VBP_W]) - bnd_t'(1);
   end

   assign inv_h  = pw[PB_INV_H];
   assign inv_v  = pw[PB_INV_V];
   assign inv_de = pw[PB_INV_DE];
   assign fall   = pw[PB_FALL];

   assign unused_fields = ^{hw[1:0], pw};
endmodule

// File: rtl/ptg_axis.sv
module ptg_axis
   import ptg_pkg::*;
#(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  axis_bnd_t        bnd,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             in_act,
   output logic             in_sync
);
   bnd_t pos;
   logic at_last;

   assign pos     = BND_W'(cnt);
   assign at_last = (pos == bnd.last);
   assign wrap    = run & step & at_last;
   assign in_act  = (pos < bnd.act_end);
   assign in_sync = (pos >= bnd.sync_start) && (pos < bnd.sync_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= at_last ? '0 : cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ptg_power_seq.sv
module ptg_power_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   input  logic pwr_req,
   output logic run,
   output logic pwr
);
   // run stays on while power is still up; power needs a running controller
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         pwr <= 1'b0;
      end else begin
         run <= en_req | pwr;
         pwr <= pwr_req & en_req & run;
      end
   end
endmodule

// File: rtl/ptg_out_stage.sv
module ptg_out_stage #(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] hcnt,
   input  logic [CNT_W-1:0] vcnt,
   input  logic             h_act,
   input  logic             v_act,
   input  logic             h_sync,
   input  logic             v_sync,
   input  logic             inv_h,
   input  logic             inv_v,
   input  logic             inv_de,
   input  logic             fall,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             frame_start,
   output logic [CNT_W-1:0] pix_x,
   output logic [CNT_W-1:0] pix_y,
   output logic             fall_edge
);
   logic origin;
   assign origin = (hcnt == '0) && (vcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync       <= 1'b0;
         vsync       <= 1'b0;
         de          <= 1'b0;
         frame_start <= 1'b0;
         pix_x       <= '0;
         pix_y       <= '0;
         fall_edge   <= 1'b0;
      end else begin
         hsync       <= (run & h_sync) ^ inv_h;
         vsync       <= (run & v_sync) ^ inv_v;
         de          <= (run & h_act & v_act) ^ inv_de;
         frame_start <= run & origin;
         pix_x       <= run ? hcnt : '0;
         pix_y       <= run ? vcnt : '0;
         fall_edge   <= fall;
      end
   end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
   import ptg_pkg::*;
#(
   parameter int unsigned CNT_W        = 11,
   parameter bit          ACT_FROM_CPL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_ce,
   input  logic             ctl_en,
   input  logic             pwr_req,
   input  logic [31:0]      h_timing,
   input  logic [31:0]      v_timing,
   input  logic [31:0]      pol_ctl,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             frame_start,
   output logic [CNT_W-1:0] pix_x,
   output logic [CNT_W-1:0] pix_y,
   output logic             panel_pwr,
   output logic             data_fall_edge
);
   generate
      if (CNT_W < MIN_CNT_W || CNT_W > BND_W) begin : g_bad_cnt_w
         $error("CNT_W must lie between MIN_CNT_W and BND_W");
      end
   endgenerate

   logic             run_q;
   logic [31:0]      sh_h, sh_v, sh_p;
   axis_bnd_t        hb, vb;
   logic             inv_h, inv_v, inv_de, fall;
   logic [CNT_W-1:0] hcnt, vcnt;
   logic             h_wrap, v_wrap, h_act, v_act, h_sync, v_sync;
   logic             frame_end;

   ptg_power_seq u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_req  (ctl_en),
      .pwr_req (pwr_req),
      .run     (run_q),
      .pwr     (panel_pwr)
   );

   assign frame_end = h_wrap & v_wrap;

   // shadow copies: transparent while stopped, reloaded only at a frame boundary while running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_h <= '0;
         sh_v <= '0;
         sh_p <= '0;
      end else if (!run_q || frame_end) begin
         sh_h <= h_timing;
         sh_v <= v_timing;
         sh_p <= pol_ctl;
      end
   end

   ptg_decode #(.ACT_FROM_CPL(ACT_FROM_CPL)) u_dec (
      .hw     (sh_h),
      .vw     (sh_v),
      .pw     (sh_p),
      .hb     (hb),
      .vb     (vb),
      .inv_h  (inv_h),
      .inv_v  (inv_v),
      .inv_de (inv_de),
      .fall   (fall)
   );

   ptg_axis #(.CNT_W(CNT_W)) u_hax (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .step    (pix_ce),
      .bnd     (hb),
      .cnt     (hcnt),
      .wrap    (h_wrap),
      .in_act  (h_act),
      .in_sync (h_sync)
   );

   ptg_axis #(.CNT_W(CNT_W)) u_vax (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .step    (h_wrap),
      .bnd     (vb),
      .cnt     (vcnt),
      .wrap    (v_wrap),
      .in_act  (v_act),
      .in_sync (v_sync)
   );

   ptg_out_stage #(.CNT_W(CNT_W)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_q),
      .hcnt        (hcnt),
      .vcnt        (vcnt),
      .h_act       (h_act),
      .v_act       (v_act),
      .h_sync      (h_sync),
      .v_sync      (v_sync),
      .inv_h       (inv_h),
      .inv_v       (inv_v),
      .inv_de      (inv_de),
      .fall        (fall),
      .hsync       (hsync),
      .vsync       (vsync),
      .de          (de),
      .frame_start (frame_start),
      .pix_x       (pix_x),
      .pix_y       (pix_y),
      .fall_edge   (data_fall_edge)
   );
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
   parameter int unsigned CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_ce,
   input logic             ctl_en,
   input logic             run_q,
   input logic             panel_pwr,
   input logic             frame_start,
   input logic [CNT_W-1:0] pix_x,
   input logic [CNT_W-1:0] pix_y
);
   AST_PWR_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(panel_pwr) |-> ($past(ctl_en) && $past(run_q))); // R7

   AST_PWR_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      panel_pwr |-> run_q); // R7

   AST_STOP_AFTER_PWR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> !$past(panel_pwr)); // R7

   AST_FS_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (pix_x == '0 && pix_y == '0)); // R4

   AST_FS_ONE_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && $past(frame_start)) |-> !$past(pix_ce, 2)); // R4

   AST_IDLE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_q) |-> (pix_x == '0 && pix_y == '0 && !frame_start)); // R6

   AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pix_ce, 2) && $past(run_q, 2) && $past(run_q)) |-> ($stable(pix_x) && $stable(pix_y))); // R9
endmodule

bind panel_timing_gen ptg_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pix_ce      (pix_ce),
   .ctl_en      (ctl_en),
   .run_q       (run_q),
   .panel_pwr   (panel_pwr),
   .frame_start (frame_start),
   .pix_x       (pix_x),
   .pix_y       (pix_y)
);

// File: tb/panel_timing_gen_tb_top.sv
`timescale 1ns/1ps
module panel_timing_gen_tb_top;
   localparam int CW = 11;

   typedef struct packed {
      int ppl; int hsw; int hfp; int hbp;
      int lpp; int vsw; int vfp; int vbp;
      int inv; int div;
   } vec_t;

   // inv: bit0 hsync, bit1 vsync, bit2 de, bit3 falling-edge flag
   localparam vec_t VECS [4] = '{
      '{0, 1, 0, 2, 2, 0, 1, 1, 0,  1},
      '{1, 3, 2, 0, 3, 1, 0, 0, 15, 1},
      '{0, 0, 4, 1, 0, 2, 2, 3, 2,  2},
      '{2, 0, 0, 0, 1, 0, 0, 0, 5,  1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_ce = 1'b1;
   logic ctl_en = 1'b0;
   logic pwr_req = 1'b0;
   logic [31:0] h_timing = '0, v_timing = '0, pol_ctl = '0;
   logic hsync, vsync, de, frame_start, panel_pwr, data_fall_edge;
   logic [CW-1:0] pix_x, pix_y;

   int ce_div = 1;
   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int m_frame, m_de, m_hs, m_vs, m_fs, m_derun, m_hsoff, m_vsoff, m_x0, m_y0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (ce_div <= 1) pix_ce <= 1'b1;
      else             pix_ce <= ~pix_ce;
   end

   panel_timing_gen #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .ctl_en(ctl_en), .pwr_req(pwr_req),
      .h_timing(h_timing), .v_timing(v_timing), .pol_ctl(pol_ctl),
      .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start),
      .pix_x(pix_x), .pix_y(pix_y), .panel_pwr(panel_pwr), .data_fall_edge(data_fall_edge)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] hword(vec_t v);
      return 32'((v.ppl << 2) | (v.hsw << 8) | (v.hfp << 16) | (v.hbp << 24));
   endfunction
   function automatic logic [31:0] vword(vec_t v);
      return 32'(v.lpp | (v.vsw << 10) | (v.vfp << 16) | (v.vbp << 24));
   endfunction
   function automatic logic [31:0] pword(vec_t v);
      // clocks-per-line field filled with an arbitrary value (R10)
      return 32'((v.inv & 1) << 12) | 32'(((v.inv >> 1) & 1) << 11) |
             32'(((v.inv >> 2) & 1) << 14) | 32'(((v.inv >> 3) & 1) << 13) | (32'h155 << 16);
   endfunction

   // measures one whole frame from a frame_start rise; optional word change at clock chg_at
   task automatic measure_frame(input int inv, input int chg_at, input logic [31:0] chg_word);
      int k;
      logic pfs, open, hs_a, vs_a, de_a;
      @(negedge clk);
      while (frame_start) @(negedge clk);
      while (!frame_start) @(negedge clk);
      m_x0 = pix_x; m_y0 = pix_y;
      m_de = 0; m_hs = 0; m_vs = 0; m_fs = 0; m_derun = 0; m_hsoff = -1; m_vsoff = -1;
      open = 1'b1; k = 0; pfs = 1'b1;
      forever begin
         hs_a = hsync ^ inv[0];
         vs_a = vsync ^ inv[1];
         de_a = de ^ inv[2];
         if (de_a) m_de++;
         if (hs_a) m_hs++;
         if (vs_a) m_vs++;
         if (frame_start) m_fs++;
         if (open && de_a) m_derun++; else open = 1'b0;
         if (hs_a && m_hsoff < 0) m_hsoff = k;
         if (vs_a && m_vsoff < 0) m_vsoff = k;
         if (k == chg_at) h_timing = chg_word;
         pfs = frame_start;
         @(negedge clk);
         k++;
         if (frame_start && !pfs) break;
      end
      m_frame = k;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // reset state (R6, R7)
      repeat (3) @(negedge clk);
      check("R6", "reset hsync", hsync, 0);
      check("R6", "reset de", de, 0);
      check("R6", "reset pix_x", pix_x, 0);
      check("R7", "reset panel_pwr", panel_pwr, 0);
      rst_n = 1'b1;

      // stopped with all inversions set: outputs at inactive level (R6, R5)
      pol_ctl = (32'h1 << 11) | (32'h1 << 12) | (32'h1 << 14);
      h_timing = hword(VECS[0]);
      v_timing = vword(VECS[0]);
      repeat (5) @(negedge clk);
      check("R6", "idle inverted hsync", hsync, 1);
      check("R6", "idle inverted vsync", vsync, 1);
      check("R6", "idle inverted de", de, 1);
      check("R6", "idle frame_start", frame_start, 0);
      check("R6", "idle pix_y", pix_y, 0);

      // table of vectors
      for (int i = 0; i < 4; i++) begin
         int ha, hfp, hsw, hbp, va, vfp, vsw, vbp, ht, vt, dv;
         ctl_en = 1'b0;
         repeat (3) @(negedge clk);
         ce_div = VECS[i].div;
         h_timing = hword(VECS[i]);
         v_timing = vword(VECS[i]);
         pol_ctl = pword(VECS[i]);
         repeat (3) @(negedge clk);
         ctl_en = 1'b1;
         ha = (VECS[i].ppl + 1) * 16; hfp = VECS[i].hfp + 1; hsw = VECS[i].hsw + 1; hbp = VECS[i].hbp + 1;
         va = VECS[i].lpp + 1; vfp = VECS[i].vfp; vsw = VECS[i].vsw + 1; vbp = VECS[i].vbp;
         ht = ha + hfp + hsw + hbp; vt = va + vfp + vsw + vbp; dv = VECS[i].div;
         measure_frame(VECS[i].inv, -1, '0);
         check("R1", $sformatf("v%0d line/frame clocks", i), m_frame, ht * vt * dv);
         check("R1", $sformatf("v%0d de run (from word, CPL ignored R10)", i), m_derun, ha * dv);
         check("R1", $sformatf("v%0d hsync offset", i), m_hsoff, (ha + hfp) * dv);
         check("R2", $sformatf("v%0d vsync offset", i), m_vsoff, (va + vfp) * ht * dv);
         check("R2", $sformatf("v%0d vsync clocks", i), m_vs, vsw * ht * dv);
         check("R5", $sformatf("v%0d hsync clocks", i), m_hs, hsw * vt * dv);
         check("R3", $sformatf("v%0d de clocks", i), m_de, ha * va * dv);
         check("R9", $sformatf("v%0d frame_start clocks", i), m_fs, dv);
         check("R4", $sformatf("v%0d origin xy", i), m_x0 + m_y0, 0);
         check("R10", $sformatf("v%0d fall flag", i), data_fall_edge, (VECS[i].inv >> 3) & 1);
      end

      // mid-frame word change is deferred to the next frame (R8)
      ctl_en = 1'b0;
      ce_div = 1;
      repeat (3) @(negedge clk);
      h_timing = hword(VECS[0]);
      v_timing = vword(VECS[0]);
      pol_ctl = pword(VECS[0]);
      repeat (3) @(negedge clk);
      ctl_en = 1'b1;
      measure_frame(0, 5, 32'(1 << 2) | (32'h1 << 8) | (32'h2 << 24));
      check("R8", "de clocks in frame with change", m_de, 16 * 3);
      measure_frame(0, -1, '0);
      check("R8", "de run next frame", m_derun, 32);
      check("R8", "de clocks next frame", m_de, 32 * 3);

      // power sequencing (R7)
      ctl_en = 1'b0;
      pwr_req = 1'b1;
      repeat (4) @(negedge clk);
      check("R7", "no power while stopped", panel_pwr, 0);
      ctl_en = 1'b1;
      @(negedge clk);
      check("R7", "power waits one cycle", panel_pwr, 0);
      @(negedge clk);
      check("R7", "power on", panel_pwr, 1);
      repeat (10) @(negedge clk);
      ctl_en = 1'b0;
      @(negedge clk);
      begin
         int xprev;
         check("R7", "power off first", panel_pwr, 0);
         xprev = pix_x;
         @(negedge clk);
         check("R7", "still running after power off", int'(pix_x != CW'(xprev)), 1);
      end
      @(negedge clk);
      check("R6", "stopped pix_x", pix_x, 0);
      check("R6", "stopped de inactive", de, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule